// File: doc/BRIEF.md
# Interrupt Return Frame Unstacker

This block unwinds the frame that an interrupt left on the stack when a processor core returns from its handler in 64-bit or compatibility mode. On a start request it takes the current stack pointer, then reads the frame through a memory read port with a valid/ready handshake. Each slot is 8 bytes. It pops the return instruction pointer, the code selector and the flags. It then decides whether the stack selector and the stack pointer must also be popped.

When a stack selector is popped, the block applies the null-selector rule. A null selector is a legal marker that no new stack descriptor is needed, but only when the return targets 64-bit code at a privilege level other than 3. In every other case a popped null selector is rejected with a fault flag, and the output registers keep their previous values. A one-cycle done pulse tells the core when the restored values are valid. Descriptor fetch, limit checks and privilege-based flag masking are left to neighbouring logic.

Top module: `iret_unstacker`

## Requirements
- R1: Reads go to rsp_i, rsp_i+8, rsp_i+16 and, when the stack is popped, rsp_i+24 and rsp_i+32, in that order. A request holds rd_valid_o and rd_addr_o unchanged until rd_ready_i accepts it. The address advances by 8 only on an accepted read.
- R2: With mode_64_i=1, exactly five reads are made: instruction pointer, code selector, flags, stack pointer, stack selector.
- R3: With mode_64_i=0, five reads are made when the popped code selector bits [1:0] differ from cur_cpl_i. Otherwise exactly three reads are made, rsp_o becomes rsp_i+24, ss_o becomes 0 and ss_popped_o becomes 0.
- R4: tgt_cpl_o equals bits [1:0] of the popped code selector. cs_o and ss_o are bits [15:0] of their slots. rip_o, rflags_o and rsp_o are the full 64-bit slot values.
- R5: A stack selector is null when its bits [15:2] are all zero; bits [1:0] are ignored. A null selector is accepted only when tgt_long_i=1 and the target level is not 3. In that case ss_null_o=1.
- R6: A null stack selector popped in any other case raises fault_o together with done_o. rip_o, cs_o, rflags_o, rsp_o, ss_o, tgt_cpl_o, ss_popped_o and ss_null_o keep their previous values.
- R7: done_o is a one-cycle pulse in the cycle after the last accepted read. The outputs hold the new values from that cycle on.
- R8: start_i is ignored while a frame is being read. The read sequence and the results follow the first request.
- R9: After reset, all outputs are zero and no read is requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin unwinding a frame |
| mode_64_i | input | 1 | 1: current mode is 64-bit, 0: compatibility |
| cur_cpl_i | input | 2 | Current privilege level |
| tgt_long_i | input | 1 | Target code segment runs in 64-bit mode |
| rsp_i | input | 64 | Stack pointer at the top of the frame |
| rd_valid_o | output | 1 | Read request |
| rd_addr_o | output | 64 | Read byte address |
| rd_ready_i | input | 1 | Read accepted, data on rd_data_i this cycle |
| rd_data_i | input | 64 | Read data |
| busy_o | output | 1 | Frame being read |
| done_o | output | 1 | Completion pulse |
| fault_o | output | 1 | Null stack selector rejected (with done_o) |
| rip_o | output | 64 | Restored instruction pointer |
| cs_o | output | 16 | Restored code selector |
| rflags_o | output | 64 | Restored flags |
| rsp_o | output | 64 | Restored stack pointer |
| ss_o | output | 16 | Restored stack selector |
| tgt_cpl_o | output | 2 | Target privilege level |
| ss_popped_o | output | 1 | Stack selector and pointer were popped |
| ss_null_o | output | 1 | Accepted null selector, no descriptor load needed |

## Verification
The assertions assume that mode_64_i, cur_cpl_i and tgt_long_i stay constant from start until the done pulse. They also assume that rd_data_i carries the slot addressed by rd_addr_o in the cycle rd_ready_i is high. The bench keeps to this. It holds the mode inputs until the completion checks are finished, and it serves data from a combinational frame model indexed by the request address. Ready is driven at random, so waits of varying length occur on every slot.

// File: rtl/iret_pkg.sv
package iret_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RIP,
    ST_CS,
    ST_FL,
    ST_RSP,
    ST_SS
  } pop_st_e;

  localparam int SEL_W = 16;
endpackage

// File: rtl/iret_pop_ctrl.sv
module iret_pop_ctrl
  import iret_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [XLEN-1:0] rsp_i,
  input  logic            rd_ready_i,
  input  logic            need_ss_i,
  output logic            rd_valid_o,
  output logic [XLEN-1:0] rd_addr_o,
  output logic            acc_o,
  output logic            last_o,
  output pop_st_e         st_o
);
  localparam logic [XLEN-1:0] SLOT = XLEN'(XLEN / 8);

  pop_st_e st_q, st_d;
  logic [XLEN-1:0] ptr_q;

  assign rd_valid_o = (st_q != ST_IDLE);
  assign rd_addr_o  = ptr_q;
  assign acc_o      = rd_valid_o && rd_ready_i;
  assign last_o     = acc_o && ((st_q == ST_SS) || (st_q == ST_FL && !need_ss_i));
  assign st_o       = st_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_RIP;
      ST_RIP:  if (acc_o) st_d = ST_CS;
      ST_CS:   if (acc_o) st_d = ST_FL;
      ST_FL:   if (acc_o) st_d = need_ss_i ? ST_RSP : ST_IDLE;
      ST_RSP:  if (acc_o) st_d = ST_SS;
      ST_SS:   if (acc_o) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      ptr_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE) begin
        if (start_i) ptr_q <= rsp_i;
      end else if (acc_o) begin
        ptr_q <= ptr_q + SLOT;
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_addr_o)); // R1
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_o && !last_o |=> rd_valid_o && rd_addr_o == $past(rd_addr_o) + SLOT); // R1
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && start_i && !rd_ready_i |=> $stable(st_q)); // R8
endmodule

// File: rtl/iret_ss_check.sv
module iret_ss_check
  import iret_pkg::*;
(
  input  logic             mode_64_i,
  input  logic [1:0]       cur_cpl_i,
  input  logic             tgt_long_i,
  input  logic [1:0]       cs_rpl_i,
  input  logic [SEL_W-1:2] ss_hi_i,
  output logic             need_ss_o,
  output logic             ss_null_o,
  output logic             ss_fault_o
);
  logic null_ok;

  // compatibility mode pops the stack only across a privilege change
  assign need_ss_o  = mode_64_i || (cs_rpl_i != cur_cpl_i);
  assign ss_null_o  = (ss_hi_i == '0);
  assign null_ok    = tgt_long_i && (cs_rpl_i != 2'd3);
  assign ss_fault_o = ss_null_o && !null_ok;
endmodule

// File: rtl/iret_frame_regs.sv
module iret_frame_regs
  import iret_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  pop_st_e          st_i,
  input  logic             acc_i,
  input  logic             last_i,
  input  logic [XLEN-1:0]  rd_data_i,
  input  logic [XLEN-1:0]  rd_addr_i,
  input  logic             ss_null_i,
  input  logic             ss_fault_i,
  output logic [1:0]       cs_rpl_o,
  output logic             done_o,
  output logic             fault_o,
  output logic [XLEN-1:0]  rip_o,
  output logic [SEL_W-1:0] cs_o,
  output logic [XLEN-1:0]  rflags_o,
  output logic [XLEN-1:0]  rsp_o,
  output logic [SEL_W-1:0] ss_o,
  output logic [1:0]       tgt_cpl_o,
  output logic             ss_popped_o,
  output logic             ss_null_o
);
  localparam logic [XLEN-1:0] SLOT = XLEN'(XLEN / 8);

  logic [XLEN-1:0]  rip_q, fl_q, rsp_q;
  logic [SEL_W-1:0] cs_q;
  logic             at_ss, reject, commit;
  logic [XLEN-1:0]  fl_fin, rsp_fin;
  logic [SEL_W-1:0] ss_fin;

  assign cs_rpl_o = cs_q[1:0];
  assign at_ss    = (st_i == ST_SS);
  assign reject   = last_i && at_ss && ss_fault_i;
  assign commit   = last_i && !reject;
  assign fl_fin   = (st_i == ST_FL) ? rd_data_i : fl_q;
  assign rsp_fin  = at_ss ? rsp_q : rd_addr_i + SLOT;
  assign ss_fin   = at_ss ? rd_data_i[SEL_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rip_q <= '0;
      cs_q  <= '0;
      fl_q  <= '0;
      rsp_q <= '0;
    end else if (acc_i) begin
      unique case (st_i)
        ST_RIP:  rip_q <= rd_data_i;
        ST_CS:   cs_q  <= rd_data_i[SEL_W-1:0];
        ST_FL:   fl_q  <= rd_data_i;
        ST_RSP:  rsp_q <= rd_data_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      fault_o     <= 1'b0;
      rip_o       <= '0;
      cs_o        <= '0;
      rflags_o    <= '0;
      rsp_o       <= '0;
      ss_o        <= '0;
      tgt_cpl_o   <= '0;
      ss_popped_o <= 1'b0;
      ss_null_o   <= 1'b0;
    end else begin
      done_o  <= last_i;
      fault_o <= reject;
      if (commit) begin
        rip_o       <= rip_q;
        cs_o        <= cs_q;
        rflags_o    <= fl_fin;
        rsp_o       <= rsp_fin;
        ss_o        <= ss_fin;
        tgt_cpl_o   <= cs_q[1:0];
        ss_popped_o <= at_ss;
        ss_null_o   <= at_ss && ss_null_i;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_FAULT_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> done_o && ss_popped_o == $past(ss_popped_o)); // R6
  AST_FAULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $stable(rip_o) && $stable(rsp_o) && $stable(ss_o) && $stable(tgt_cpl_o)); // R6
  AST_NULL_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !fault_o && ss_null_o |-> tgt_cpl_o != 2'd3 && ss_o[SEL_W-1:2] == '0); // R5
  AST_TGT_FROM_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !fault_o |-> tgt_cpl_o == cs_o[1:0]); // R4
endmodule

// File: rtl/iret_unstacker.sv
module iret_unstacker
  import iret_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             mode_64_i,
  input  logic [1:0]       cur_cpl_i,
  input  logic             tgt_long_i,
  input  logic [XLEN-1:0]  rsp_i,
  output logic             rd_valid_o,
  output logic [XLEN-1:0]  rd_addr_o,
  input  logic             rd_ready_i,
  input  logic [XLEN-1:0]  rd_data_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             fault_o,
  output logic [XLEN-1:0]  rip_o,
  output logic [SEL_W-1:0] cs_o,
  output logic [XLEN-1:0]  rflags_o,
  output logic [XLEN-1:0]  rsp_o,
  output logic [SEL_W-1:0] ss_o,
  output logic [1:0]       tgt_cpl_o,
  output logic             ss_popped_o,
  output logic             ss_null_o
);
  pop_st_e    st;
  logic       acc, last, need_ss, null_sel, null_fault;
  logic [1:0] cs_rpl;

  iret_pop_ctrl #(.XLEN(XLEN)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .rsp_i      (rsp_i),
    .rd_ready_i (rd_ready_i),
    .need_ss_i  (need_ss),
    .rd_valid_o (rd_valid_o),
    .rd_addr_o  (rd_addr_o),
    .acc_o      (acc),
    .last_o     (last),
    .st_o       (st)
  );

  iret_ss_check u_check (
    .mode_64_i  (mode_64_i),
    .cur_cpl_i  (cur_cpl_i),
    .tgt_long_i (tgt_long_i),
    .cs_rpl_i   (cs_rpl),
    .ss_hi_i    (rd_data_i[SEL_W-1:2]),
    .need_ss_o  (need_ss),
    .ss_null_o  (null_sel),
    .ss_fault_o (null_fault)
  );

  iret_frame_regs #(.XLEN(XLEN)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .st_i        (st),
    .acc_i       (acc),
    .last_i      (last),
    .rd_data_i   (rd_data_i),
    .rd_addr_i   (rd_addr_o),
    .ss_null_i   (null_sel),
    .ss_fault_i  (null_fault),
    .cs_rpl_o    (cs_rpl),
    .done_o      (done_o),
    .fault_o     (fault_o),
    .rip_o       (rip_o),
    .cs_o        (cs_o),
    .rflags_o    (rflags_o),
    .rsp_o       (rsp_o),
    .ss_o        (ss_o),
    .tgt_cpl_o   (tgt_cpl_o),
    .ss_popped_o (ss_popped_o),
    .ss_null_o   (ss_null_o)
  );

  assign busy_o = rd_valid_o;

  AST_LONG_POPS_STACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !fault_o && mode_64_i |-> ss_popped_o); // R2
  AST_SAME_LEVEL_NO_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !fault_o && !ss_popped_o |-> !mode_64_i && tgt_cpl_o == cur_cpl_i); // R3
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !rd_valid_o); // R7
endmodule

// File: tb/tb_iret_unstacker.sv
module tb_iret_unstacker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        mode64 = 1'b1;
  logic [1:0]  cpl = 2'd0;
  logic        tlong = 1'b1;
  logic [63:0] rsp_in = '0;
  logic        rd_valid, rd_ready = 1'b0;
  logic [63:0] rd_addr, rd_data;
  logic        busy, done, fault, ss_popped, ss_null;
  logic [63:0] rip, rflags, rsp_out;
  logic [15:0] cs, ss;
  logic [1:0]  tcpl;

  logic [63:0] frame [5];
  logic [63:0] base = '0;
  logic [63:0] off;
  logic [63:0] rec [8];
  int          nrd = 0;
  int          errors = 0, checks = 0;

  always #2 clk = ~clk;

  iret_unstacker dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_64_i(mode64),
    .cur_cpl_i(cpl), .tgt_long_i(tlong), .rsp_i(rsp_in),
    .rd_valid_o(rd_valid), .rd_addr_o(rd_addr), .rd_ready_i(rd_ready),
    .rd_data_i(rd_data), .busy_o(busy), .done_o(done), .fault_o(fault),
    .rip_o(rip), .cs_o(cs), .rflags_o(rflags), .rsp_o(rsp_out), .ss_o(ss),
    .tgt_cpl_o(tcpl), .ss_popped_o(ss_popped), .ss_null_o(ss_null)
  );

  always_comb begin
    off = (rd_addr - base) >> 3;
    rd_data = (off < 64'd5) ? frame[off[2:0]] : 64'hdead_beef_dead_beef;
  end

  always @(posedge clk) begin
    #1 rd_ready = ($urandom_range(0, 2) != 0);
  end

  always @(negedge clk) begin
    if (rd_valid && rd_ready && nrd < 8) begin
      rec[nrd] = rd_addr;
      nrd = nrd + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit is_null(input logic [15:0] s);
    return s[15:2] == 14'd0;
  endfunction

  task automatic run_case(input bit m64, input logic [1:0] ccpl, input bit tl,
                          input logic [63:0] b, input bit spur);
    logic [15:0] ecs, ess;
    bit          pop, nul, flt;
    int          n_exp, wd;
    logic [63:0] p_rip, p_fl, p_rsp;
    logic [15:0] p_cs, p_ss;
    logic [1:0]  p_tc;
    logic        p_pop, p_nul;
    ecs = frame[1][15:0];
    ess = frame[4][15:0];
    pop = m64 || (ecs[1:0] != ccpl);
    n_exp = pop ? 5 : 3;
    nul = pop && is_null(ess);
    flt = nul && !(tl && ecs[1:0] != 2'd3);
    p_rip = rip; p_fl = rflags; p_rsp = rsp_out; p_cs = cs; p_ss = ss;
    p_tc = tcpl; p_pop = ss_popped; p_nul = ss_null;
    @(negedge clk);
    mode64 = m64; cpl = ccpl; tlong = tl; base = b; rsp_in = b; nrd = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (spur) begin
      @(negedge clk);
      start = 1'b1; rsp_in = b + 64'h1000;
      @(negedge clk);
      start = 1'b0; rsp_in = b;
    end
    wd = 0;
    while (!done && wd < 200) begin
      @(negedge clk);
      wd++;
    end
    chk(done == 1'b1, "R7 done pulse seen", 64'(done), 64'd1);
    chk(nrd == n_exp, pop ? "R2 five reads" : "R3 three reads", 64'(nrd), 64'(n_exp));
    for (int k = 0; k < n_exp && k < 8; k++)
      chk(rec[k] == b + 64'(8 * k), spur ? "R8 addr after spurious start" : "R1 read address",
          rec[k], b + 64'(8 * k));
    chk(fault == flt, "R6 fault flag", 64'(fault), 64'(flt));
    if (flt) begin
      chk(rip == p_rip && cs == p_cs && rflags == p_fl, "R6 hold rip/cs/flags", rip, p_rip);
      chk(rsp_out == p_rsp && ss == p_ss && tcpl == p_tc && ss_popped == p_pop && ss_null == p_nul,
          "R6 hold stack outputs", rsp_out, p_rsp);
    end else begin
      chk(rip == frame[0], "R4 rip", rip, frame[0]);
      chk(cs == ecs, "R4 cs", 64'(cs), 64'(ecs));
      chk(rflags == frame[2], "R4 rflags", rflags, frame[2]);
      chk(tcpl == ecs[1:0], "R4 target cpl", 64'(tcpl), 64'(ecs[1:0]));
      chk(ss_popped == pop, pop ? "R2 stack popped" : "R3 stack not popped", 64'(ss_popped), 64'(pop));
      chk(rsp_out == (pop ? frame[3] : b + 64'd24), "R3 rsp result", rsp_out, pop ? frame[3] : b + 64'd24);
      chk(ss == (pop ? ess : 16'd0), "R3 ss result", 64'(ss), 64'(pop ? ess : 16'd0));
      chk(ss_null == nul, "R5 null marker", 64'(ss_null), 64'(nul));
    end
    @(negedge clk);
    chk(done == 1'b0, "R7 done one cycle", 64'(done), 64'd0);
  endtask

  task automatic set_frame(input logic [63:0] r, input logic [15:0] c, input logic [63:0] f,
                           input logic [63:0] sp, input logic [15:0] s);
    frame[0] = r;
    frame[1] = {48'h1234_5678_9abc, c};
    frame[2] = f;
    frame[3] = sp;
    frame[4] = {48'hfeed_face_cafe, s};
  endtask

  initial begin
    void'($urandom(32'd7));
    for (int i = 0; i < 5; i++) frame[i] = '0;
    #3;
    chk(!rd_valid && !done && !fault && rip == 0 && rsp_out == 0 && ss == 0 && tcpl == 0,
        "R9 reset outputs", rip, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rd_valid && !busy, "R9 idle after reset", 64'(rd_valid), 64'd0);

    set_frame(64'h1111, 16'h0010, 64'h202, 64'h7000, 16'h002b);
    run_case(1'b1, 2'd0, 1'b1, 64'h8000, 1'b0);   // 64-bit, same level
    set_frame(64'h2222, 16'h0023, 64'h246, 64'h7100, 16'h0003);
    run_case(1'b1, 2'd0, 1'b0, 64'h8100, 1'b0);   // null SS, target not long: fault
    set_frame(64'h3333, 16'h0008, 64'h2, 64'h7200, 16'h0000);
    run_case(1'b1, 2'd0, 1'b1, 64'h8200, 1'b0);   // null SS accepted
    set_frame(64'h4444, 16'h001b, 64'h3, 64'h7300, 16'h0003);
    run_case(1'b1, 2'd0, 1'b1, 64'h8300, 1'b0);   // null SS to level 3: fault
    set_frame(64'h5555, 16'h0013, 64'h4, 64'h7400, 16'h0020);
    run_case(1'b0, 2'd3, 1'b0, 64'h8400, 1'b0);   // compat, same level
    set_frame(64'h6666, 16'h0013, 64'h5, 64'h7500, 16'h0004);
    run_case(1'b0, 2'd0, 1'b0, 64'h8500, 1'b1);   // compat, level change, TI=1 not null
    set_frame(64'h7777, 16'h0011, 64'h6, 64'h7600, 16'h0001);
    run_case(1'b0, 2'd2, 1'b1, 64'hffff_ffff_ffff_fff0, 1'b1);

    for (int n = 0; n < 200; n++) begin
      logic [15:0] c, s;
      c = 16'($urandom());
      s = ($urandom_range(0, 2) == 0) ? {14'd0, 2'($urandom())} : 16'($urandom());
      set_frame({$urandom(), $urandom()}, c, {$urandom(), $urandom()}, {$urandom(), $urandom()}, s);
      run_case(1'($urandom()), 2'($urandom()), 1'($urandom()),
               {$urandom(), $urandom()}, ($urandom_range(0, 4) == 0));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #3_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule